// File: doc/BRIEF.md
# Video Encoder Power and Load-Sense Control

This block is the register-mapped control slice of a video output encoder. Software reaches it through a byte-wide read/write port. It holds a power register and a load-detect register. The power register holds a three-bit power field, an output-standard select and an active-low soft reset. The block decodes the power field into enables for the composite DAC, the luma and chroma DACs, the core logic and the buffered clock outputs. The output-standard select switches the DAC trio between luma/chroma/composite and red/green/blue. In red/green/blue mode it also enables the composite sync pin.

The load-detect register runs a software-driven sense step. Software sets the sense bit while the power field is in normal mode, and a drive signal is raised towards the DACs. Software then clears the sense bit, and the three comparator inputs are captured as per-DAC load-present flags. Those flags mean nothing until one full sense step has completed.

The soft reset bit returns all other state in the block to its default. It does not clear itself, and software must write it back to 1 to leave reset.

Top module: `vpc_pwr_ctl`

## Requirements
- R1: After `rst_n` is released, the power register reads 0x0B (select 0, soft reset 1, power field 011), the detect register reads 0x00, all DAC and core enables are 1 and `sense_drive` is 0.
- R2: The power register is at address `PWR_ADDR` (0x0E): bit 4 is the output-standard select, bit 3 is the active-low soft reset and bits 2:0 are the power field. Bits 7:5 read 0 and ignore writes.
- R3: Power-field decode (composite, luma, chroma, core enables): 000 gives 0,1,1,1; 001 gives 0,0,0,0; 010 gives 1,0,0,1; 011 gives 1,1,1,1; any 1xx gives 0,0,0,0.
- R4: `clkbuf_en` is 1 exactly when `clk_pin_out` is 1 and power-field bit 2 is 0. It follows both without a clock.
- R5: `rgb_sel` and `csync_en` both equal the output-standard select bit.
- R6: A write of 0 to the soft reset bit sets the select to 0, the power field to 011, the load flags to 0 and ends any sense step, all on that edge. While the bit is 0, other fields of both registers ignore writes. A write with bit 3 = 1 only releases the reset and loads no other field.
- R7: The detect register is at address `DET_ADDR` (0x10): bit 3 is the luma-load flag, bit 2 the chroma-load flag, bit 1 the composite-load flag and bit 0 the sense bit. The sense bit always reads 0, and bits 7:4 read 0.
- R8: A write of sense = 1 while the power field is not 011 is ignored. No drive is raised and the flags keep their value.
- R9: After a write of sense = 1 in normal mode, `sense_drive` is 1 from the next cycle. A later write of sense = 0 drops the drive and stores `{cmp_y, cmp_c, cmp_cvbs}` into flag bits 3:1 at that write's edge.
- R10: If the power field leaves 011 during a sense step, the drive drops at once and the step ends without changing the flags.
- R11: Addresses other than the two registers read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| clk_pin_out | input | 1 | Shared clock pin configured as an output |
| cmp_y | input | 1 | Luma DAC load comparator |
| cmp_c | input | 1 | Chroma DAC load comparator |
| cmp_cvbs | input | 1 | Composite DAC load comparator |
| cvbs_dac_en | output | 1 | Composite DAC enable |
| y_dac_en | output | 1 | Luma DAC enable |
| c_dac_en | output | 1 | Chroma DAC enable |
| core_en | output | 1 | Core circuitry enable |
| clkbuf_en | output | 1 | Buffered clock output enable |
| rgb_sel | output | 1 | DACs carry red/green/blue instead of luma/chroma/composite |
| csync_en | output | 1 | Composite sync pin enable |
| sense_drive | output | 1 | Load-sense drive to the DACs |
| soft_rst_n | output | 1 | Soft reset to the rest of the chip, active low |

## Verification
The hardest state to reach is a sense step cut short: a drive in progress whose power field changes before software clears the sense bit. A soft reset hitting already-latched flags is similar. The stimulus first latches a known, non-zero comparator pattern and opens a new step. It then rewrites the power field or clears the reset bit before closing the step, with a different comparator pattern present. The old flags must survive the abort, and must be cleared by the soft reset. Writes issued while the soft reset is held are then shown to leave both registers at their defaults.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int PD_W = 3;
  localparam int FLAG_W = 3;
  localparam logic [PD_W-1:0] PD_NORMAL = 3'b011;
  localparam logic [PD_W-1:0] PD_DEFAULT = PD_NORMAL;

  typedef struct packed {
    logic cvbs;
    logic y;
    logic c;
    logic core;
  } grp_en_t;

  function automatic grp_en_t pd_decode(input logic [PD_W-1:0] pd);
    grp_en_t e;
    e = '0;
    if (!pd[2]) begin
      unique case (pd[1:0])
        2'b00: e = '{cvbs: 1'b0, y: 1'b1, c: 1'b1, core: 1'b1};
        2'b01: e = '{cvbs: 1'b0, y: 1'b0, c: 1'b0, core: 1'b0};
        2'b10: e = '{cvbs: 1'b1, y: 1'b0, c: 1'b0, core: 1'b1};
        default: e = '{cvbs: 1'b1, y: 1'b1, c: 1'b1, core: 1'b1};
      endcase
    end
    return e;
  endfunction

  function automatic logic clkbuf_on(input logic [PD_W-1:0] pd, input logic pin_out);
    return pin_out & ~pd[2];
  endfunction
endpackage

// File: rtl/vpc_pwr_reg.sv
module vpc_pwr_reg
  import vpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [4:0]      wbits,
  output logic            scart_q,
  output logic            rstb_q,
  output logic [PD_W-1:0] pd_q,
  output logic            soft_rst_evt
);
  assign soft_rst_evt = wr & ~wbits[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scart_q <= 1'b0;
      rstb_q  <= 1'b1;
      pd_q    <= PD_DEFAULT;
    end else if (wr) begin
      rstb_q <= wbits[3];
      if (!wbits[3] || !rstb_q) begin
        scart_q <= 1'b0;
        pd_q    <= PD_DEFAULT;
      end else begin
        scart_q <= wbits[4];
        pd_q    <= wbits[2:0];
      end
    end
  end
endmodule

// File: rtl/vpc_pwr_decode.sv
module vpc_pwr_decode
  import vpc_pkg::*;
(
  input  logic [PD_W-1:0] pd,
  input  logic            pin_out,
  output grp_en_t         en,
  output logic            clkbuf_en
);
  always_comb begin
    en        = pd_decode(pd);
    clkbuf_en = clkbuf_on(pd, pin_out);
  end
endmodule

// File: rtl/vpc_sense.sv
module vpc_sense
  import vpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic              sense_bit,
  input  logic              pd_normal,
  input  logic [FLAG_W-1:0] cmp,
  output logic              drive,
  output logic [FLAG_W-1:0] flags_q,
  output logic              sense_start,
  output logic              sense_end,
  output logic              sense_abort
);
  logic active_q;

  assign sense_start = ~clr & wr & sense_bit & pd_normal & ~active_q;
  assign sense_end   = ~clr & wr & ~sense_bit & pd_normal & active_q;
  assign sense_abort = ~clr & active_q & ~pd_normal;
  assign drive       = active_q & pd_normal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      flags_q  <= '0;
    end else if (clr) begin
      active_q <= 1'b0;
      flags_q  <= '0;
    end else if (sense_abort) begin
      active_q <= 1'b0;
    end else if (sense_start) begin
      active_q <= 1'b1;
    end else if (sense_end) begin
      active_q <= 1'b0;
      flags_q  <= cmp;
    end
  end
endmodule

// File: rtl/vpc_pwr_ctl.sv
module vpc_pwr_ctl
  import vpc_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] PWR_ADDR = 8'h0E,
  parameter logic [AW-1:0] DET_ADDR = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          clk_pin_out,
  input  logic          cmp_y,
  input  logic          cmp_c,
  input  logic          cmp_cvbs,
  output logic          cvbs_dac_en,
  output logic          y_dac_en,
  output logic          c_dac_en,
  output logic          core_en,
  output logic          clkbuf_en,
  output logic          rgb_sel,
  output logic          csync_en,
  output logic          sense_drive,
  output logic          soft_rst_n
);
  localparam int PWR_BITS = 5;
  localparam int DET_BITS = FLAG_W + 1;

  logic            pwr_wr, det_wr;
  logic            scart_q, rstb_q, soft_rst_evt;
  logic [PD_W-1:0] pd_q;
  logic            pd_normal, sense_clr;
  logic [FLAG_W-1:0] flags_q;
  logic            sense_start, sense_end, sense_abort;
  grp_en_t         grp_en;

  assign pwr_wr    = reg_we & (reg_addr == PWR_ADDR);
  assign det_wr    = reg_we & (reg_addr == DET_ADDR);
  assign pd_normal = (pd_q == PD_NORMAL);
  assign sense_clr = soft_rst_evt | ~rstb_q;

  vpc_pwr_reg u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (pwr_wr),
    .wbits        (reg_wdata[PWR_BITS-1:0]),
    .scart_q      (scart_q),
    .rstb_q       (rstb_q),
    .pd_q         (pd_q),
    .soft_rst_evt (soft_rst_evt)
  );

  vpc_pwr_decode u_dec (
    .pd        (pd_q),
    .pin_out   (clk_pin_out),
    .en        (grp_en),
    .clkbuf_en (clkbuf_en)
  );

  vpc_sense u_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (sense_clr),
    .wr          (det_wr),
    .sense_bit   (reg_wdata[0]),
    .pd_normal   (pd_normal),
    .cmp         ({cmp_y, cmp_c, cmp_cvbs}),
    .drive       (sense_drive),
    .flags_q     (flags_q),
    .sense_start (sense_start),
    .sense_end   (sense_end),
    .sense_abort (sense_abort)
  );

  assign cvbs_dac_en = grp_en.cvbs;
  assign y_dac_en    = grp_en.y;
  assign c_dac_en    = grp_en.c;
  assign core_en     = grp_en.core;
  assign rgb_sel     = scart_q;
  assign csync_en    = scart_q;
  assign soft_rst_n  = rstb_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == PWR_ADDR)
      reg_rdata[PWR_BITS-1:0] = {scart_q, rstb_q, pd_q};
    else if (reg_addr == DET_ADDR)
      reg_rdata[DET_BITS-1:0] = {flags_q, 1'b0};
  end
endmodule

// File: rtl/vpc_pwr_ctl_chk.sv
module vpc_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rstb_q,
  input logic [2:0] pd_q,
  input logic       scart_q,
  input logic [2:0] flags_q,
  input logic [2:0] cmp,
  input logic       soft_rst_evt,
  input logic       sense_start,
  input logic       sense_end,
  input logic       sense_drive,
  input logic       cvbs_en,
  input logic       y_en,
  input logic       c_en,
  input logic       core_en,
  input logic       clkbuf_en
);
  AST_RESET_HOLDS_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !rstb_q |-> (pd_q == 3'b011 && !scart_q && flags_q == 3'b000 && !sense_drive)); // R6

  AST_DRIVE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    sense_drive |-> pd_q == 3'b011); // R10

  AST_NO_START_OFF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |-> pd_q == 3'b011); // R8

  AST_LATCH_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    sense_end |=> flags_q == $past(cmp)); // R9

  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_end && !soft_rst_evt) |=> $stable(flags_q)); // R10

  AST_START_RAISES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |=> sense_drive); // R9

  AST_CORE_OFF_DACS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> !(cvbs_en || y_en || c_en)); // R3

  AST_FULL_DOWN_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q[2] |-> !clkbuf_en && !core_en); // R4
endmodule

bind vpc_pwr_ctl vpc_pwr_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rstb_q       (rstb_q),
  .pd_q         (pd_q),
  .scart_q      (scart_q),
  .flags_q      (flags_q),
  .cmp          ({cmp_y, cmp_c, cmp_cvbs}),
  .soft_rst_evt (soft_rst_evt),
  .sense_start  (sense_start),
  .sense_end    (sense_end),
  .sense_drive  (sense_drive),
  .cvbs_en      (cvbs_dac_en),
  .y_en         (y_dac_en),
  .c_en         (c_dac_en),
  .core_en      (core_en),
  .clkbuf_en    (clkbuf_en)
);

// File: tb/test_vpc_pwr_ctl.sv
module test_vpc_pwr_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       clk_pin_out = 1'b0;
  logic       cmp_y = 1'b0, cmp_c = 1'b0, cmp_cvbs = 1'b0;
  logic       cvbs_dac_en, y_dac_en, c_dac_en, core_en, clkbuf_en;
  logic       rgb_sel, csync_en, sense_drive, soft_rst_n;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_sel = 0, m_rstb = 1, m_pd = 3, m_sense = 0;
  int m_fy = 0, m_fc = 0, m_fv = 0;

  always #4 clk = ~clk;

  vpc_pwr_ctl i_vpc_pwr_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_pin_out(clk_pin_out),
    .cmp_y(cmp_y), .cmp_c(cmp_c), .cmp_cvbs(cmp_cvbs),
    .cvbs_dac_en(cvbs_dac_en), .y_dac_en(y_dac_en), .c_dac_en(c_dac_en),
    .core_en(core_en), .clkbuf_en(clkbuf_en), .rgb_sel(rgb_sel),
    .csync_en(csync_en), .sense_drive(sense_drive), .soft_rst_n(soft_rst_n)
  );

  task automatic chk(input string what, input string req, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", req, cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ev, ey, ec, eco, rd;
    ev = 0; ey = 0; ec = 0; eco = 0;
    if (m_pd == 0) begin ey = 1; ec = 1; eco = 1; end
    else if (m_pd == 2) begin ev = 1; eco = 1; end
    else if (m_pd == 3) begin ev = 1; ey = 1; ec = 1; eco = 1; end
    chk("cvbs_dac_en", "R3", int'(cvbs_dac_en), ev);
    chk("y_dac_en", "R3", int'(y_dac_en), ey);
    chk("c_dac_en", "R3", int'(c_dac_en), ec);
    chk("core_en", "R3", int'(core_en), eco);
    chk("clkbuf_en", "R4", int'(clkbuf_en), (clk_pin_out && m_pd < 4) ? 1 : 0);
    chk("rgb_sel", "R5", int'(rgb_sel), m_sel);
    chk("csync_en", "R5", int'(csync_en), m_sel);
    chk("soft_rst_n", "R6", int'(soft_rst_n), m_rstb);
    chk("sense_drive", "R9", int'(sense_drive), (m_sense && m_pd == 3) ? 1 : 0);
    if (reg_addr == 8'h0E) begin
      rd = m_sel * 16 + m_rstb * 8 + m_pd;
      chk("rdata pwr", "R2", int'(reg_rdata), rd);
    end else if (reg_addr == 8'h10) begin
      rd = m_fy * 8 + m_fc * 4 + m_fv * 2;
      chk("rdata det", "R7", int'(reg_rdata), rd);
    end else begin
      chk("rdata other", "R11", int'(reg_rdata), 0);
    end
  endtask

  task automatic model_edge();
    int n_sel, n_rstb, n_pd, n_sense, n_fy, n_fc, n_fv;
    bit clear;
    n_sel = m_sel; n_rstb = m_rstb; n_pd = m_pd; n_sense = m_sense;
    n_fy = m_fy; n_fc = m_fc; n_fv = m_fv;
    clear = (m_rstb == 0) || (reg_we && reg_addr == 8'h0E && !reg_wdata[3]);
    if (reg_we && reg_addr == 8'h0E) begin
      n_rstb = reg_wdata[3];
      if (reg_wdata[3] && m_rstb == 1) begin
        n_sel = reg_wdata[4]; n_pd = int'(reg_wdata[2:0]);
      end else begin
        n_sel = 0; n_pd = 3;
      end
    end
    if (clear) begin
      n_sense = 0; n_fy = 0; n_fc = 0; n_fv = 0;
    end else if (m_sense && m_pd != 3) begin
      n_sense = 0;
    end else if (reg_we && reg_addr == 8'h10) begin
      if (reg_wdata[0] && m_pd == 3) n_sense = 1;
      else if (!reg_wdata[0] && m_sense == 1) begin
        n_sense = 0; n_fy = cmp_y; n_fc = cmp_c; n_fv = cmp_cvbs;
      end
    end
    m_sel = n_sel; m_rstb = n_rstb; m_pd = n_pd; m_sense = n_sense;
    m_fy = n_fy; m_fc = n_fc; m_fv = n_fv;
  endtask

  // one cycle: drive after the falling edge, check, then advance model at the rising edge
  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input logic [2:0] cmp, input bit cko);
    reg_we = we; reg_addr = a; reg_wdata = d;
    {cmp_y, cmp_c, cmp_cvbs} = cmp; clk_pin_out = cko;
    #1;
    n_vec++;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [2:0] cmp);
    step(1'b1, a, d, cmp, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] cmp);
    step(1'b0, a, 8'h00, cmp, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd(8'h0E, 3'b000);
    rd(8'h10, 3'b111);
    // R2 R3 R4 R5: every power code, upper bits set, both pin settings
    for (int p = 0; p < 8; p++) begin
      cur_req = "R3";
      wr(8'h0E, 8'hE8 | 8'(p) | ((p % 2 == 1) ? 8'h10 : 8'h00), 3'b000);
      step(1'b0, 8'h0E, 8'h00, 3'b000, 1'b0);
      step(1'b0, 8'h0E, 8'h00, 3'b000, 1'b1);
    end
    cur_req = "R2";
    wr(8'h0E, 8'h0B, 3'b000);
    rd(8'h0E, 3'b000);
    // R9 sense steps with several comparator patterns
    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin
      logic [2:0] pat;
      pat = (k == 0) ? 3'b101 : (k == 1) ? 3'b010 : (k == 2) ? 3'b111 : 3'b000;
      wr(8'h10, 8'h01, ~pat);
      rd(8'h10, ~pat);
      wr(8'h10, 8'hF0, pat);
      rd(8'h10, ~pat);
    end
    // R8 sense blocked outside normal mode
    cur_req = "R8";
    wr(8'h10, 8'h01, 3'b110);
    wr(8'h10, 8'h00, 3'b110);
    wr(8'h0E, 8'h09, 3'b000);
    wr(8'h10, 8'h01, 3'b001);
    rd(8'h10, 3'b001);
    wr(8'h10, 8'h00, 3'b001);
    rd(8'h10, 3'b001);
    wr(8'h0E, 8'h0B, 3'b000);
    wr(8'h10, 8'h00, 3'b011);
    rd(8'h10, 3'b011);
    // R10 abort by leaving normal mode
    cur_req = "R10";
    wr(8'h10, 8'h01, 3'b000);
    wr(8'h0E, 8'h0A, 3'b111);
    rd(8'h10, 3'b111);
    wr(8'h0E, 8'h0B, 3'b111);
    wr(8'h10, 8'h00, 3'b111);
    rd(8'h10, 3'b111);
    // R6 soft reset
    cur_req = "R6";
    wr(8'h10, 8'h01, 3'b000);
    wr(8'h10, 8'h00, 3'b111);
    wr(8'h0E, 8'h1B, 3'b000);
    wr(8'h10, 8'h01, 3'b000);
    wr(8'h0E, 8'h12, 3'b000);
    rd(8'h10, 3'b000);
    rd(8'h0E, 3'b000);
    wr(8'h0E, 8'h11, 3'b000);
    wr(8'h10, 8'h01, 3'b000);
    wr(8'h10, 8'h00, 3'b111);
    rd(8'h10, 3'b111);
    wr(8'h0E, 8'h1A, 3'b000);
    rd(8'h0E, 3'b000);
    wr(8'h0E, 8'h1A, 3'b000);
    rd(8'h0E, 3'b000);
    // R11 unmapped addresses
    cur_req = "R11";
    wr(8'h0F, 8'hFF, 3'b000);
    rd(8'h0F, 3'b000);
    wr(8'h11, 8'h00, 3'b000);
    rd(8'h0E, 3'b000);
    rd(8'h10, 3'b000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule